// File: doc/BRIEF.md
# Receive Bit Packer with End-of-Frame Gap Detection

This block sits on the receive side of a low-rate radio baseband, after the correlator. Each bit time the correlator issues one strobe. With it come a flag that says whether the bit time held valid correlated data and the data bit itself. The block optionally complements each valid bit and shifts it into a byte, most significant bit first. Each finished byte goes into a data register for the host.

A frame ends when a programmable number of consecutive invalid bit times has passed after valid data. At that point the block declares end of frame (EOF) and moves any partly filled byte into the data register, together with the number of bits it holds. It then sets a sticky interrupt flag. That flag drives an interrupt pin, which has four drive styles: two push-pull polarities, open drain and open source. The pin is presented as a value and an output enable, so that the high-impedance states can be modelled.

Top module: `rx_deser_eof`

## Requirements
- R1: After reset, `rd_stb` and `eof_evt` are 0 and the interrupt pin is deasserted. In CMOS modes this means `irq_oe`=1 and the inactive level on `irq_o`. In open modes it means `irq_oe`=0.
- R2: Valid bits are packed MSB first. After the eighth valid bit, `rd_data` holds the byte, `rd_nbits` reads 0 (meaning a full byte) and `rd_stb` is high for one cycle. All of these appear in the cycle after the clock edge that sampled the strobe.
- R3: When `rx_invert` is 1, every valid data bit is complemented before it is packed. When it is 0, the bit is packed as received.
- R4: A strobe with `bit_valid`=0 adds nothing to the byte being packed. Cycles without `bit_strobe` are ignored.
- R5: With EOF length L on `eof_len` (0 to 7), `eof_evt` pulses for one cycle after the (L+1)th consecutive invalid strobe that follows a valid one. With L=0, it pulses after the first invalid strobe.
- R6: A valid strobe restarts the count of invalid strobes from zero.
- R7: Invalid strobes produce no EOF before the first valid bit after reset. They also produce none after an EOF until a new valid bit has been received.
- R8: At EOF, a partly filled byte is placed right-aligned in `rd_data`, with zeros above it. `rd_nbits` gives its bit count (1 to 7) and `rd_stb` pulses. If no bits are pending, `rd_stb` stays 0 and `rd_data` is unchanged.
- R9: EOF sets an interrupt flag, which holds until a one-cycle `irq_clr` pulse clears it. If an EOF and `irq_clr` occur in the same cycle, the flag is set.
- R10: `irq_mode` selects the pin drive:
  - 3 (open drain): `irq_oe`=flag, `irq_o`=0.
  - 2 (open source): `irq_oe`=flag, `irq_o`=1.
  - 1 (push-pull, active high): `irq_oe`=1, `irq_o`=flag.
  - 0 (push-pull, active low): `irq_oe`=1, `irq_o`=not flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_strobe | input | 1 | One pulse per bit time |
| bit_valid | input | 1 | Bit time held valid correlated data |
| bit_data | input | 1 | Received data bit |
| rx_invert | input | 1 | Complement received bits |
| eof_len | input | 3 | Invalid bit times that end a frame, minus one |
| irq_mode | input | 2 | Interrupt pin drive style |
| irq_clr | input | 1 | Clears the interrupt flag |
| rd_data | output | 8 | Data register for the host |
| rd_nbits | output | 3 | Bits in `rd_data`; 0 means eight |
| rd_stb | output | 1 | `rd_data` was just loaded |
| eof_evt | output | 1 | End-of-frame pulse |
| irq_o | output | 1 | Interrupt pin value |
| irq_oe | output | 1 | Interrupt pin output enable |

## Verification
The assertions check on every cycle that:
- the pin follows its selected drive style;
- the flag holds until it is cleared, and a clear loses to a coinciding EOF;
- an EOF or a data strobe follows only a strobe of the matching kind;
- a byte loaded without an EOF is always full;
- two EOFs never occur back to back.

Only the bench scenarios can show the rest. That covers the byte values with and without inversion, and the exact bit time at which EOF fires for each gap length. It also covers the restart of the gap count by a valid bit, silence before the first valid bit and after an EOF, and the right-aligned partial byte with its count.

// File: rtl/rxd_pkg.sv
// Shared types for the receive packer: interrupt pin drive styles.
package rxd_pkg;
    typedef enum logic [1:0] {
        DRV_PP_LOW  = 2'b00,
        DRV_PP_HIGH = 2'b01,
        DRV_OPEN_SRC = 2'b10,
        DRV_OPEN_DRN = 2'b11
    } irq_drive_e;
endpackage

// File: rtl/rxd_packer.sv
// Shifts accepted bits into a byte MSB first and loads the output register
// on a full byte or on a flush with pending bits.
// Assumes push and flush never occur in the same cycle.
module rxd_packer #(
    parameter int BYTE_W = 8,
    localparam int CNT_W = $clog2(BYTE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              bit_in,
    input  logic              flush,
    output logic [BYTE_W-1:0] out_data,
    output logic [CNT_W-1:0]  out_nbits,
    output logic              out_stb
);
    logic [BYTE_W-1:0] shreg;
    logic [CNT_W-1:0]  fill;
    logic              last_bit;

    // Purpose: the next push completes a byte.
    assign last_bit = (fill == CNT_W'(BYTE_W - 1));

    // Purpose: shift bits in and load the output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg     <= '0;
            fill      <= '0;
            out_data  <= '0;
            out_nbits <= '0;
            out_stb   <= 1'b0;
        end else begin
            out_stb <= 1'b0;
            if (push) begin
                if (last_bit) begin
                    out_data  <= {shreg[BYTE_W-2:0], bit_in};
                    out_nbits <= '0;
                    out_stb   <= 1'b1;
                    shreg     <= '0;
                    fill      <= '0;
                end else begin
                    shreg <= {shreg[BYTE_W-2:0], bit_in};
                    fill  <= fill + 1'b1;
                end
            end else if (flush && (fill != '0)) begin
                out_data  <= shreg;
                out_nbits <= fill;
                out_stb   <= 1'b1;
                shreg     <= '0;
                fill      <= '0;
            end
        end
    end
endmodule

// File: rtl/rxd_gap_det.sv
// Counts consecutive invalid bit times after valid data and flags end of
// frame. It arms on a valid bit and disarms on EOF, so idle time never
// produces a second event. The counter never exceeds the limit.
module rxd_gap_det #(
    parameter int LEN_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stb,
    input  logic             valid,
    input  logic [LEN_W-1:0] gap_len,
    output logic             eof_now
);
    logic             armed;
    logic [LEN_W-1:0] gap;

    // Purpose: an invalid strobe that completes the gap while armed.
    assign eof_now = stb && !valid && armed && (gap >= gap_len);

    // Purpose: arm on valid data, count invalid strobes, disarm on EOF.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
            gap   <= '0;
        end else if (stb) begin
            if (valid) begin
                armed <= 1'b1;
                gap   <= '0;
            end else if (armed) begin
                if (eof_now) begin
                    armed <= 1'b0;
                    gap   <= '0;
                end else begin
                    gap <= gap + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/rxd_irq_pin.sv
// Sticky interrupt flag and the pin driver with four drive styles.
// A set in the same cycle as a clear wins.
module rxd_irq_pin
    import rxd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set,
    input  logic       clr,
    input  logic [1:0] mode,
    output logic       flag,
    output logic       pin_o,
    output logic       pin_oe
);
    irq_drive_e drv;

    // Purpose: hold the interrupt until the host clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)   flag <= 1'b0;
        else if (set) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end

    assign drv = irq_drive_e'(mode);

    // Purpose: map the flag onto a pin value and an output enable.
    always_comb begin
        unique case (drv)
            DRV_OPEN_DRN: begin pin_o = 1'b0;  pin_oe = flag; end
            DRV_OPEN_SRC: begin pin_o = 1'b1;  pin_oe = flag; end
            DRV_PP_HIGH:  begin pin_o = flag;  pin_oe = 1'b1; end
            default:      begin pin_o = !flag; pin_oe = 1'b1; end
        endcase
    end
endmodule

// File: rtl/rx_deser_eof.sv
// Top: receive packer with end-of-frame gap detection and an interrupt pin.
// Assumes at most one bit strobe per clock cycle.
module rx_deser_eof #(
    parameter int BYTE_W = 8,
    parameter int LEN_W  = 3,
    localparam int CNT_W = $clog2(BYTE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_strobe,
    input  logic              bit_valid,
    input  logic              bit_data,
    input  logic              rx_invert,
    input  logic [LEN_W-1:0]  eof_len,
    input  logic [1:0]        irq_mode,
    input  logic              irq_clr,
    output logic [BYTE_W-1:0] rd_data,
    output logic [CNT_W-1:0]  rd_nbits,
    output logic              rd_stb,
    output logic              eof_evt,
    output logic              irq_o,
    output logic              irq_oe
);
    logic eof_now;
    logic push;
    logic rx_bit;
    logic irq_flag;

    // Purpose: accept only valid strobes, with the optional complement.
    assign push   = bit_strobe && bit_valid;
    assign rx_bit = bit_data ^ rx_invert;

    rxd_gap_det #(.LEN_W(LEN_W)) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .stb     (bit_strobe),
        .valid   (bit_valid),
        .gap_len (eof_len),
        .eof_now (eof_now)
    );

    rxd_packer #(.BYTE_W(BYTE_W)) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .bit_in    (rx_bit),
        .flush     (eof_now),
        .out_data  (rd_data),
        .out_nbits (rd_nbits),
        .out_stb   (rd_stb)
    );

    rxd_irq_pin u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .set    (eof_now),
        .clr    (irq_clr),
        .mode   (irq_mode),
        .flag   (irq_flag),
        .pin_o  (irq_o),
        .pin_oe (irq_oe)
    );

    // Purpose: register the end-of-frame pulse alongside the data register.
    always_ff @(posedge clk) begin
        if (!rst_n) eof_evt <= 1'b0;
        else        eof_evt <= eof_now;
    end
endmodule

// File: rtl/rxd_checker.sv
// Assertion checker bound to rx_deser_eof; it observes the block and drives nothing.
module rxd_checker #(
    parameter int CNT_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bit_strobe,
    input logic             bit_valid,
    input logic             irq_clr,
    input logic [1:0]       irq_mode,
    input logic             rd_stb,
    input logic [CNT_W-1:0] rd_nbits,
    input logic             eof_evt,
    input logic             irq_o,
    input logic             irq_oe,
    input logic             irq_flag
);
    AST_EOF_AFTER_INVALID: assert property (@(posedge clk) disable iff (!rst_n) eof_evt |-> $past(bit_strobe && !bit_valid)); // R5
    AST_NO_DOUBLE_EOF: assert property (@(posedge clk) disable iff (!rst_n) eof_evt |=> !eof_evt); // R7
    AST_LOAD_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n) rd_stb |-> $past(bit_strobe)); // R4
    AST_FULL_WITHOUT_EOF: assert property (@(posedge clk) disable iff (!rst_n) (rd_stb && !eof_evt) |-> (rd_nbits == '0)); // R2
    AST_PARTIAL_ON_EOF: assert property (@(posedge clk) disable iff (!rst_n) (rd_stb && eof_evt) |-> (rd_nbits != '0)); // R8
    AST_FLAG_ON_EOF: assert property (@(posedge clk) disable iff (!rst_n) eof_evt |-> irq_flag); // R9
    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) ($past(irq_flag) && !$past(irq_clr)) |-> irq_flag); // R9
    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n) ($past(irq_clr) && !eof_evt) |-> !irq_flag); // R9
    AST_OPEN_DRAIN: assert property (@(posedge clk) disable iff (!rst_n) (irq_mode == 2'b11) |-> (irq_oe == irq_flag && !irq_o)); // R10
    AST_OPEN_SOURCE: assert property (@(posedge clk) disable iff (!rst_n) (irq_mode == 2'b10) |-> (irq_oe == irq_flag && irq_o)); // R10
    AST_PUSH_PULL: assert property (@(posedge clk) disable iff (!rst_n) (irq_mode[1] == 1'b0) |-> (irq_oe && (irq_o == (irq_flag ~^ irq_mode[0])))); // R10
endmodule

bind rx_deser_eof rxd_checker #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_strobe (bit_strobe),
    .bit_valid  (bit_valid),
    .irq_clr    (irq_clr),
    .irq_mode   (irq_mode),
    .rd_stb     (rd_stb),
    .rd_nbits   (rd_nbits),
    .eof_evt    (eof_evt),
    .irq_o      (irq_o),
    .irq_oe     (irq_oe),
    .irq_flag   (irq_flag)
);

// File: tb/sim_rx_deser_eof.sv
module sim_rx_deser_eof;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_strobe = 1'b0, bit_valid = 1'b0, bit_data = 1'b0;
    logic       rx_invert = 1'b0, irq_clr = 1'b0;
    logic [2:0] eof_len = 3'd0;
    logic [1:0] irq_mode = 2'b01;
    logic [7:0] rd_data;
    logic [2:0] rd_nbits;
    logic       rd_stb, eof_evt, irq_o, irq_oe;

    int total = 0, bad = 0;
    bit done = 1'b0;
    // reference model state
    int m_arm = 0, m_gap = 0, m_sh = 0, m_cnt = 0, m_flag = 0;

    always #10 clk = ~clk; // 50 MHz

    rx_deser_eof u0 (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_pin(input logic [1:0] mode, input int flag);
        case (mode)
            2'b11: return {flag != 0, 1'b0};
            2'b10: return {flag != 0, 1'b1};
            2'b01: return {1'b1, flag != 0};
            default: return {1'b1, flag == 0};
        endcase
    endfunction

    task automatic chk_pin(input string req);
        chk({irq_oe, irq_o} == exp_pin(irq_mode, m_flag), req, {irq_oe, irq_o}, exp_pin(irq_mode, m_flag));
    endtask

    // One bit time: drive at a falling edge, check at the next one.
    task automatic do_bit(input bit v, input bit d, input bit clr);
        bit e_stb = 0, e_eof = 0;
        int e_data = 0, e_nb = 0;
        int b = d ^ rx_invert;
        if (v) begin
            m_arm = 1; m_gap = 0;
            m_sh = ((m_sh << 1) | b) & 8'hFF; m_cnt++;
            if (m_cnt == 8) begin
                e_stb = 1; e_data = m_sh; e_nb = 0; m_sh = 0; m_cnt = 0;
            end
        end else if (m_arm != 0) begin
            if (m_gap >= int'(eof_len)) begin
                e_eof = 1; m_arm = 0; m_gap = 0;
                if (m_cnt != 0) begin
                    e_stb = 1; e_data = m_sh; e_nb = m_cnt; m_sh = 0; m_cnt = 0;
                end
            end else m_gap++;
        end
        if (e_eof) m_flag = 1; else if (clr) m_flag = 0;
        @(negedge clk);
        bit_strobe = 1; bit_valid = v; bit_data = d; irq_clr = clr;
        @(negedge clk);
        bit_strobe = 0; irq_clr = 0;
        chk(rd_stb == e_stb, v ? "R2" : "R8", rd_stb, e_stb);
        if (e_stb) begin
            chk(rd_data == 8'(e_data), v ? "R2" : "R8", rd_data, e_data);
            chk(rd_nbits == 3'(e_nb), v ? "R2" : "R8", rd_nbits, e_nb);
        end
        chk(eof_evt == e_eof, "R5", eof_evt, e_eof);
        chk_pin("R10");
    endtask

    task automatic send_byte(input logic [7:0] val);
        for (int i = 7; i >= 0; i--) do_bit(1'b1, val[i], 1'b0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(!rd_stb && !eof_evt, "R4", {rd_stb, eof_evt}, 0);
        end
    endtask

    // Watchdog: counts as one failed check and still prints the summary.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!rd_stb && !eof_evt, "R1", {rd_stb, eof_evt}, 0);
        chk({irq_oe, irq_o} == 2'b10, "R1", {irq_oe, irq_o}, 2'b10);
        // R7 idle before any valid data
        for (int i = 0; i < 5; i++) do_bit(1'b0, 1'b0, 1'b0);
        chk(!eof_evt && !irq_o, "R7", eof_evt, 0);
        // R2 MSB-first byte
        send_byte(8'hA5);
        chk(rd_data == 8'hA5 && rd_nbits == 0, "R2", rd_data, 8'hA5);
        // R5 with L=0: EOF on the first invalid bit, empty packer gives no load (R8)
        do_bit(1'b0, 1'b0, 1'b0);
        chk(eof_evt && !rd_stb && rd_data == 8'hA5, "R8", {eof_evt, rd_stb}, 2'b10);
        chk(irq_o == 1'b1, "R9", irq_o, 1);
        idle(3);
        chk_pin("R9");
        do_bit(1'b0, 1'b0, 1'b1);
        chk(irq_o == 1'b0, "R9", irq_o, 0);
        // R3 invert
        rx_invert = 1'b1;
        send_byte(8'h3C);
        chk(rd_data == 8'hC3, "R3", rd_data, 8'hC3);
        rx_invert = 1'b0;
        // R4 invalid strobes between valid bits, L=7
        eof_len = 3'd7;
        do_bit(1,1,0); do_bit(1,0,0); do_bit(1,1,0); do_bit(1,1,0);
        for (int i = 0; i < 3; i++) do_bit(1'b0, 1'b1, 1'b0);
        idle(2);
        do_bit(1,0,0); do_bit(1,1,0); do_bit(1,1,0); do_bit(1,0,0);
        chk(rd_stb && rd_data == 8'hB6, "R4", rd_data, 8'hB6);
        // R6 gap restart with L=2, then partial flush R8
        eof_len = 3'd2;
        do_bit(1,1,0); do_bit(0,0,0); do_bit(0,0,0); do_bit(1,1,0);
        do_bit(0,0,0); do_bit(0,0,0);
        chk(!eof_evt, "R6", eof_evt, 0);
        do_bit(0,0,1); // event and clear together: event wins (R9)
        chk(eof_evt && rd_stb && rd_data == 8'h03 && rd_nbits == 3'd2, "R8", rd_data, 8'h03);
        chk(irq_o == 1'b1, "R9", irq_o, 1);
        // R7 no second EOF during a long idle gap
        for (int i = 0; i < 20; i++) begin
            do_bit(1'b0, 1'b0, 1'b0);
            chk(!eof_evt, "R7", eof_evt, 0);
        end
        // R10 every drive style with the flag set, then cleared
        for (int m = 0; m < 4; m++) begin
            irq_mode = 2'(m);
            @(negedge clk); chk_pin("R10");
        end
        do_bit(1'b0, 1'b0, 1'b1);
        for (int m = 0; m < 4; m++) begin
            irq_mode = 2'(m);
            @(negedge clk); chk_pin("R10");
        end
        // Random phase
        for (int n = 0; n < 4000; n++) begin
            if ($urandom_range(0, 49) == 0) eof_len = 3'($urandom_range(0, 7));
            if ($urandom_range(0, 99) == 0) rx_invert = ~rx_invert;
            if ($urandom_range(0, 29) == 0) irq_mode = 2'($urandom_range(0, 3));
            do_bit($urandom_range(0, 9) < 6, 1'($urandom), $urandom_range(0, 19) == 0);
            if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 2));
        end
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule